// File: doc/BRIEF.md
# Event Fragment Writer with Start-Address Table

This block moves the 32-bit words of a single readout channel from a front-end FIFO into a 2K-word circular buffer. The words of one event arrive as a fragment that opens with a group-open word and ends with a group-close word. When a fragment opens, the block records its start address in a small table of start addresses and leaves that start location free. It then writes the opening word and every following word at the next addresses, up to and including the closing word. After that it fills the free start location with a channel header. The header carries the channel number and a flag that marks a fragment with no payload.

Finished fragments are counted. A readout sequencer, which is not part of this block, sees the oldest recorded start address and the event-present flag. It reports each fragment it has drained on a one-cycle done input. Memory writes go through a shared port that grants one write per grant cycle. A word that cannot be written stays in the FIFO, which happens when there is no grant, when the buffer lacks room, or when the table is full.

Top module: `frag_writer`

## Requirements
- R1: A word with bits 31:28 = 4'hA opens a fragment. While the block is waiting for a fragment to open, accepting such a word records the current write address as the fragment's start in the start-address table. The oldest unreleased start is shown on `lut_head`.
- R2: The opening word is written at start+1. Each following word is written at the next address in turn, up to and including the word with bits 31:28 = 4'hD, which closes the fragment.
- R3: After the closing word, the next granted write puts the channel header at the start address. The header has bits 31:28 = 4'h1, bits 19:16 = the `CHAN_ID` parameter, bit 8 = empty flag, and all other bits 0.
- R4: The empty flag (header bit 8) is 1 exactly when the closing word directly follows the opening word.
- R5: The event count rises by one in the cycle after the header write. `evt_present` is 1 whenever the count is non-zero. Both are 0 after reset.
- R6: Words that arrive while the block waits for an opening word, and are not opening words, are popped and dropped without a memory write.
- R7: `mem_we` is asserted only in a cycle with `mem_grant`. Without a grant, no word is popped except a dropped one.
- R8: The table holds 16 starts. With 16 unreleased starts, `lut_full` is 1 and an opening word stays in the FIFO (not popped, not written).
- R9: Addresses wrap modulo 2048. A word is not taken when the buffer lacks room: an opening word needs 2 free locations, any other word needs 1. Free space ends at the oldest unreleased start. `buf_full` is 1 when no location is free, and no unreleased location is overwritten.
- R10: A pulse on `rd_done` with a non-zero count lowers the count by one and releases the oldest table entry, so `lut_head` moves to the next start. With a zero count, the pulse has no effect.
- R11: A header write and an `rd_done` pulse in the same cycle leave the count unchanged, while the oldest table entry is still released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_valid | input | 1 | Front-end FIFO holds a word |
| fifo_data | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | FIFO head taken in this cycle |
| mem_grant | input | 1 | Shared memory port granted for one write |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 11 | Memory write address in the channel buffer |
| mem_wdata | output | 32 | Memory write data |
| rd_done | input | 1 | Readout drained the oldest fragment |
| evt_present | output | 1 | At least one finished fragment is stored |
| evt_count | output | 5 | Number of finished fragments not yet released |
| lut_head | output | 11 | Start address of the oldest unreleased fragment |
| lut_full | output | 1 | Start-address table holds 16 entries |
| buf_full | output | 1 | Circular buffer has no free location |

## Verification
A wrong write pointer shows up on `mem_addr` at the very next granted write. A stale fragment start or a wrong empty flag shows up when the header lands, one granted cycle after the closing word. Counter faults appear on `evt_count` one cycle after the header write or the done pulse. Table pointer faults appear on `lut_head` and `lut_full` right after a release or the sixteenth open, and space-accounting faults show when a word is taken that should have stalled, or when a released region is not reused after the buffer has wrapped.

// File: rtl/fw_pkg.sv
package fw_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned ID_W   = 4;

   localparam logic [3:0] TAG_OPEN  = 4'hA;
   localparam logic [3:0] TAG_CLOSE = 4'hD;
   localparam logic [3:0] TAG_HDR   = 4'h1;

   typedef enum logic [1:0] {
      PH_HUNT  = 2'd0,
      PH_BODY  = 2'd1,
      PH_PATCH = 2'd2
   } phase_t;

   function automatic logic [WORD_W-1:0] build_header(input logic [ID_W-1:0] id,
                                                      input logic            empty);
      logic [WORD_W-1:0] h;
      h        = '0;
      h[31:28] = TAG_HDR;
      h[19:16] = id;
      h[8]     = empty;
      return h;
   endfunction

endpackage

// File: rtl/fw_addr_table.sv
module fw_addr_table #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned TBL_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              release_i,
   output logic [ADDR_W-1:0] head_addr,
   output logic              full,
   output logic              empty
);
   localparam int unsigned DEPTH = 1 << TBL_AW;
   localparam int unsigned PTR_W = TBL_AW + 1;

   logic [PTR_W-1:0]  wp_q, rp_q;
   logic [DEPTH-1:0]  wen;
   logic [ADDR_W-1:0] slot [DEPTH];

   // one write enable per entry, decoded from the write pointer
   for (genvar e = 0; e < DEPTH; e++) begin : g_dec
      assign wen[e] = push && (wp_q[TBL_AW-1:0] == TBL_AW'(e));
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (wen[e]) slot[e] <= push_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push)      wp_q <= wp_q + PTR_W'(1);
         if (release_i) rp_q <= rp_q + PTR_W'(1);
      end
   end

   assign empty     = (wp_q == rp_q);
   assign full      = (wp_q[TBL_AW] != rp_q[TBL_AW]) &&
                      (wp_q[TBL_AW-1:0] == rp_q[TBL_AW-1:0]);
   assign head_addr = slot[rp_q[TBL_AW-1:0]];

endmodule

// File: rtl/fw_space.sv
module fw_space #(
   parameter int unsigned ADDR_W = 11
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] oldest_start,
   input  logic              tbl_empty,
   output logic              room_open,
   output logic              room_word,
   output logic              no_room
);
   localparam int unsigned FREE_W = ADDR_W + 1;
   localparam logic [FREE_W-1:0] DEPTH = FREE_W'(1) << ADDR_W;

   logic [ADDR_W-1:0] gap;
   logic [FREE_W-1:0] free_n;

   // live region runs from the oldest start up to the write pointer
   assign gap       = oldest_start - wr_addr;
   assign free_n    = tbl_empty ? DEPTH : {1'b0, gap};
   assign room_open = (free_n >= FREE_W'(2));
   assign room_word = (free_n != '0);
   assign no_room   = (free_n == '0);

endmodule

// File: rtl/fw_event_counter.sv
module fw_event_counter #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec_req,
   output logic          dec_ok,
   output logic [CW-1:0] count,
   output logic          present
);
   logic [CW-1:0] cnt_q;

   assign dec_ok = dec_req && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count   = cnt_q;
   assign present = (cnt_q != '0);

endmodule

// File: rtl/fw_sequencer.sv
module fw_sequencer
   import fw_pkg::*;
#(
   parameter int unsigned    ADDR_W  = 11,
   parameter logic [ID_W-1:0] CHAN_ID = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_valid,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              mem_grant,
   input  logic              tbl_full,
   input  logic              room_open,
   input  logic              room_word,
   output logic              fifo_pop,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              tbl_push,
   output logic [ADDR_W-1:0] tbl_push_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              hdr_done,
   output logic              hunting,
   output logic              patching
);
   phase_t            ph_q;
   logic [ADDR_W-1:0] wr_q, start_q;
   logic              seen_q;
   logic              is_open, is_close;

   assign is_open  = (fifo_data[31:28] == TAG_OPEN);
   assign is_close = (fifo_data[31:28] == TAG_CLOSE);

   always_comb begin
      fifo_pop  = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = wr_q;
      mem_wdata = fifo_data;
      tbl_push  = 1'b0;
      hdr_done  = 1'b0;
      unique case (ph_q)
         PH_HUNT: begin
            if (fifo_valid) begin
               if (!is_open) begin
                  fifo_pop = 1'b1;
               end else if (mem_grant && !tbl_full && room_open) begin
                  fifo_pop = 1'b1;
                  mem_we   = 1'b1;
                  mem_addr = wr_q + ADDR_W'(1);
                  tbl_push = 1'b1;
               end
            end
         end
         PH_BODY: begin
            if (fifo_valid && mem_grant && room_word) begin
               fifo_pop = 1'b1;
               mem_we   = 1'b1;
            end
         end
         PH_PATCH: begin
            if (mem_grant) begin
               mem_we    = 1'b1;
               mem_addr  = start_q;
               mem_wdata = build_header(CHAN_ID, !seen_q);
               hdr_done  = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_HUNT;
         wr_q    <= '0;
         start_q <= '0;
         seen_q  <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_HUNT: begin
               if (tbl_push) begin
                  start_q <= wr_q;
                  wr_q    <= wr_q + ADDR_W'(2);
                  seen_q  <= 1'b0;
                  ph_q    <= PH_BODY;
               end
            end
            PH_BODY: begin
               if (fifo_pop) begin
                  wr_q <= wr_q + ADDR_W'(1);
                  if (is_close) ph_q   <= PH_PATCH;
                  else          seen_q <= 1'b1;
               end
            end
            PH_PATCH: begin
               if (hdr_done) ph_q <= PH_HUNT;
            end
            default: ph_q <= PH_HUNT;
         endcase
      end
   end

   assign tbl_push_addr = wr_q;
   assign wr_addr       = wr_q;
   assign hunting       = (ph_q == PH_HUNT);
   assign patching      = (ph_q == PH_PATCH);

endmodule

// File: rtl/frag_writer.sv
module frag_writer
   import fw_pkg::*;
#(
   parameter int unsigned     BUF_AW  = 11,
   parameter int unsigned     LUT_AW  = 4,
   parameter logic [ID_W-1:0] CHAN_ID = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_valid,
   input  logic [31:0]       fifo_data,
   output logic              fifo_pop,
   input  logic              mem_grant,
   output logic              mem_we,
   output logic [BUF_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              rd_done,
   output logic              evt_present,
   output logic [LUT_AW:0]   evt_count,
   output logic [BUF_AW-1:0] lut_head,
   output logic              lut_full,
   output logic              buf_full
);
   localparam int unsigned CNT_W = LUT_AW + 1;

   if (BUF_AW < 2 || BUF_AW > 20) begin : g_bad_buf
      $error("frag_writer: BUF_AW out of range");
   end
   if (LUT_AW < 1 || LUT_AW > 8) begin : g_bad_lut
      $error("frag_writer: LUT_AW out of range");
   end
   if ((1 << LUT_AW) > (1 << (BUF_AW - 1))) begin : g_bad_ratio
      $error("frag_writer: table deeper than buffer can hold");
   end

   logic              tbl_push, tbl_full, tbl_empty;
   logic [BUF_AW-1:0] tbl_push_addr, wr_addr;
   logic              room_open, room_word;
   logic              hdr_done, cnt_dec_ok;
   logic              hunting, patching;

   fw_sequencer #(
      .ADDR_W  (BUF_AW),
      .CHAN_ID (CHAN_ID)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .fifo_valid    (fifo_valid),
      .fifo_data     (fifo_data),
      .mem_grant     (mem_grant),
      .tbl_full      (tbl_full),
      .room_open     (room_open),
      .room_word     (room_word),
      .fifo_pop      (fifo_pop),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .tbl_push      (tbl_push),
      .tbl_push_addr (tbl_push_addr),
      .wr_addr       (wr_addr),
      .hdr_done      (hdr_done),
      .hunting       (hunting),
      .patching      (patching)
   );

   fw_addr_table #(
      .ADDR_W (BUF_AW),
      .TBL_AW (LUT_AW)
   ) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tbl_push),
      .push_addr (tbl_push_addr),
      .release_i (cnt_dec_ok),
      .head_addr (lut_head),
      .full      (tbl_full),
      .empty     (tbl_empty)
   );

   fw_space #(
      .ADDR_W (BUF_AW)
   ) u_space (
      .wr_addr      (wr_addr),
      .oldest_start (lut_head),
      .tbl_empty    (tbl_empty),
      .room_open    (room_open),
      .room_word    (room_word),
      .no_room      (buf_full)
   );

   fw_event_counter #(
      .CW (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (hdr_done),
      .dec_req (rd_done),
      .dec_ok  (cnt_dec_ok),
      .count   (evt_count),
      .present (evt_present)
   );

   assign lut_full = tbl_full;

endmodule

// File: rtl/frag_writer_chk.sv
module frag_writer_chk #(
   parameter int unsigned CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_valid,
   input logic [31:0]   fifo_data,
   input logic          fifo_pop,
   input logic          mem_grant,
   input logic          mem_we,
   input logic          buf_full,
   input logic          lut_full,
   input logic [CW-1:0] evt_count,
   input logic          hdr_inc,
   input logic          dec_ok,
   input logic          tbl_push,
   input logic          hunting,
   input logic          patching
);
   // R7: the shared port is only written when granted
   a_r7_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_grant);

   // R6: a dropped word before any opening word causes no write
   a_r6_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (hunting && fifo_pop && fifo_data[31:28] != 4'hA) |-> !mem_we);

   // R8: no new start is recorded while the table is full
   a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      lut_full |-> !tbl_push);

   // R9: with no free location only the reserved header slot may be written
   a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && mem_we) |-> patching);

   // R5: the count moves only after a header write or a release
   a_r5_count_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_count != $past(evt_count)) |-> ($past(hdr_inc) || $past(dec_ok)));

   // R11: header write and release in one cycle cancel
   a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_inc && dec_ok) |=> $stable(evt_count));

   // R10: nothing is released from an empty count
   a_r10_no_release_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_count == '0) |-> !dec_ok);

   // R7: without grant and without a droppable word nothing leaves the FIFO
   a_r7_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_grant && fifo_valid && fifo_data[31:28] == 4'hA) |-> !fifo_pop);

endmodule

bind frag_writer frag_writer_chk #(.CW(LUT_AW + 1)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_valid (fifo_valid),
   .fifo_data  (fifo_data),
   .fifo_pop   (fifo_pop),
   .mem_grant  (mem_grant),
   .mem_we     (mem_we),
   .buf_full   (buf_full),
   .lut_full   (lut_full),
   .evt_count  (evt_count),
   .hdr_inc    (hdr_done),
   .dec_ok     (cnt_dec_ok),
   .tbl_push   (tbl_push),
   .hunting    (hunting),
   .patching   (patching)
);

// File: tb/frag_writer_bench.sv
module frag_writer_bench;
   localparam logic [3:0] ID = 4'd5;
   localparam logic [31:0] HDR_FULL  = 32'h1005_0000;
   localparam logic [31:0] HDR_EMPTY = 32'h1005_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_valid;
   logic [31:0] fifo_data;
   logic        fifo_pop;
   logic        mem_grant = 1'b1;
   logic        mem_we;
   logic [10:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        rd_done = 1'b0;
   logic        evt_present;
   logic [4:0]  evt_count;
   logic [10:0] lut_head;
   logic        lut_full;
   logic        buf_full;

   logic [31:0] stim [0:8191];
   logic [12:0] rd, wi;
   logic [31:0] bmem [0:2047];
   int          wcnt = 0;
   int          nchk = 0;
   int          nfail = 0;

   always #10 clk = ~clk;

   frag_writer #(.BUF_AW(11), .LUT_AW(4), .CHAN_ID(ID)) u_frag_writer (
      .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
      .fifo_pop(fifo_pop), .mem_grant(mem_grant), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .rd_done(rd_done), .evt_present(evt_present),
      .evt_count(evt_count), .lut_head(lut_head), .lut_full(lut_full), .buf_full(buf_full)
   );

   // front-end FIFO model
   assign fifo_valid = (rd != wi);
   assign fifo_data  = stim[rd];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd <= '0;
      else if (fifo_pop) rd <= rd + 13'd1;
   end

   // shared memory model
   always @(posedge clk) begin
      if (mem_we) begin
         bmem[mem_addr] <= mem_wdata;
         wcnt <= wcnt + 1;
      end
   end

   // expected contents after the first stream: {req, addr, data}
   localparam logic [46:0] EXPV [8] = '{
      {4'd3, 11'd0, HDR_FULL},        // R3 header at start, R4 flag clear
      {4'd2, 11'd1, 32'hA000_0011},   // R2 opening word at start+1
      {4'd2, 11'd2, 32'h3000_0001},
      {4'd2, 11'd3, 32'h3000_0002},
      {4'd2, 11'd4, 32'hD000_0003},   // R2 closing word kept
      {4'd4, 11'd5, HDR_EMPTY},       // R4 empty fragment flagged
      {4'd2, 11'd6, 32'hA000_0012},
      {4'd2, 11'd7, 32'hD000_0002}
   };
   localparam logic [31:0] STREAM [7] = '{
      32'h1234_5678, 32'hA000_0011, 32'h3000_0001, 32'h3000_0002,
      32'hD000_0003, 32'hA000_0012, 32'hD000_0002
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] w);
      stim[wi] = w;
      wi = wi + 13'd1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rd_done = 1'b0;
      mem_grant = 1'b1;
      wi = '0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic pulse_done();
      rd_done = 1'b1;
      step(1);
      rd_done = 1'b0;
      step(1);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog act=timeout exp=finished");
      report();
      $finish;
   end

   initial begin
      int w0;
      int hit;
      for (int a = 0; a < 2048; a++) bmem[a] = '0;
      wi = '0;
      do_reset();

      // R5 reset state
      chk("R5 count after reset", 32'(evt_count), 32'd0);
      chk("R5 present after reset", 32'(evt_present), 32'd0);
      chk("R8 table not full after reset", 32'(lut_full), 32'd0);
      chk("R7 no write after reset", 32'(mem_we), 32'd0);

      // stimulus table walk, grant withheld at the opening word
      for (int k = 0; k < 7; k++) begin
         if (k == 1) begin
            w0 = wcnt;
            mem_grant = 1'b0;
            put(STREAM[k]);
            step(3);
            chk("R7 opening word held without grant", 32'(rd), 32'd1);
            chk("R7 no write without grant", 32'(wcnt - w0), 32'd0);
            mem_grant = 1'b1;
         end else begin
            put(STREAM[k]);
            if (k == 0) begin
               step(3);
               chk("R6 orphan popped", 32'(rd), 32'd1);
               chk("R6 orphan not written", 32'(wcnt), 32'd0);
            end
         end
      end
      step(20);
      for (int k = 0; k < 8; k++)
         chk($sformatf("R%0d word at %0d", EXPV[k][46:43], EXPV[k][42:32]),
             bmem[EXPV[k][42:32]], EXPV[k][31:0]);
      chk("R5 two fragments counted", 32'(evt_count), 32'd2);
      chk("R5 present set", 32'(evt_present), 32'd1);
      chk("R1 oldest start", 32'(lut_head), 32'd0);

      // R10 release
      pulse_done();
      chk("R10 count lowered", 32'(evt_count), 32'd1);
      chk("R10 head advanced", 32'(lut_head), 32'd5);

      // R11 header write coincides with release
      put(32'hA000_0021);
      put(32'hD000_0022);
      hit = 0;
      for (int t = 0; t < 20 && hit == 0; t++) begin
         @(negedge clk);
         if (mem_we && mem_wdata[31:28] == 4'h1) begin
            hit = 1;
            rd_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0;
         end
      end
      chk("R11 header seen", 32'(hit), 32'd1);
      chk("R11 count unchanged", 32'(evt_count), 32'd1);
      chk("R11 head released", 32'(lut_head), 32'd8);
      chk("R4 empty header at 8", bmem[8], HDR_EMPTY);

      // R10 release at zero ignored
      pulse_done();
      chk("R10 count to zero", 32'(evt_count), 32'd0);
      pulse_done();
      chk("R10 zero stays zero", 32'(evt_count), 32'd0);
      chk("R5 present clear", 32'(evt_present), 32'd0);
      put(32'hA000_0031);
      put(32'hD000_0032);
      step(10);
      chk("R10 table untouched by ignored release", 32'(lut_head), 32'd11);
      chk("R10 count after new fragment", 32'(evt_count), 32'd1);

      // R8 table full
      do_reset();
      for (int k = 0; k < 16; k++) begin
         put(32'hA000_0100 + 32'(k));
         put(32'hD000_0200 + 32'(k));
      end
      step(100);
      chk("R8 sixteen counted", 32'(evt_count), 32'd16);
      chk("R8 table full", 32'(lut_full), 32'd1);
      w0 = wcnt;
      put(32'hA000_0077);
      put(32'hD000_0078);
      step(5);
      chk("R8 opening word held", 32'(rd), 32'(wi - 13'd2));
      chk("R8 no write while full", 32'(wcnt - w0), 32'd0);
      pulse_done();
      step(10);
      chk("R8 held word written after release", bmem[49], 32'hA000_0077);
      chk("R3 header after release", bmem[48], HDR_EMPTY);
      chk("R8 count back at 16", 32'(evt_count), 32'd16);
      chk("R10 head after release", 32'(lut_head), 32'd3);

      // R9 wrap
      do_reset();
      put(32'hA000_0900);
      for (int k = 0; k < 2044; k++) put(32'h3000_0000 + 32'(k));
      put(32'hD000_0901);
      step(2100);
      chk("R9 closing word at 2046", bmem[2046], 32'hD000_0901);
      chk("R3 long header", bmem[0], HDR_FULL);
      chk("R5 long counted", 32'(evt_count), 32'd1);
      pulse_done();
      put(32'hA000_0099);
      put(32'h3000_0ABC);
      put(32'hD000_0098);
      step(10);
      chk("R9 header at 2047", bmem[2047], HDR_FULL);
      chk("R9 opening word wrapped to 0", bmem[0], 32'hA000_0099);
      chk("R9 data at 1", bmem[1], 32'h3000_0ABC);
      chk("R9 closing word at 2", bmem[2], 32'hD000_0098);
      chk("R1 wrapped start", 32'(lut_head), 32'd2047);

      // R9 buffer full
      put(32'hA000_0555);
      for (int k = 0; k < 2043; k++) put(32'h3100_0000 + 32'(k));
      step(2100);
      chk("R9 last fitting word", bmem[2046], 32'h3100_0000 + 32'd2041);
      chk("R9 buffer full", 32'(buf_full), 32'd1);
      chk("R9 one word held", 32'(rd), 32'(wi - 13'd1));
      chk("R9 live header kept", bmem[2047], HDR_FULL);

      report();
      $finish;
   end

endmodule